// File: doc/BRIEF.md
# Multiplexed Parallel Port Sequencer

This block sits between a word-oriented requester (a DMA engine or the core) and an external parallel bus whose sixteen pins carry both the address and the data. A command names a start address, a direction, a count of 32-bit words and an address stride. The sequencer splits every word into bus data cycles: four byte cycles in the narrow mode, or two halfword cycles in the wide mode. It places an address-latch cycle in front of a data cycle only when the external latch would otherwise hold a stale address.

The sequencer keeps a copy of the upper address bits that were last latched. In the narrow mode, a byte whose page (address bits 15:8) matches that copy goes straight to its data cycle, so a sequential run pays for one latch cycle per 256 bytes. In the wide mode, every halfword is preceded by a latch cycle. A zero stride needs only one latch cycle for the whole command. Every latch cycle and every data cycle lasts a programmable number of core clocks.

Top module: `mpp_sequencer`

## Requirements
- R1: After reset, `ale`, `rd_stb`, `wr_stb`, `busy`, `rd_valid` and `wd_ready` are low, `ad_oe` is 0, and `cmd_ready` is high.
- R2: In narrow mode (`mode16`=0), a word takes four byte data cycles, lane 0 (bits 7:0) first. During a data cycle, `ad_out[15:8]` carries address bits 7:0 and `ad_out[7:0]` carries the write byte. Read bytes are taken from `ad_in[7:0]`. `ad_oe` is 2'b11 for writes and 2'b10 for reads.
- R3: In wide mode (`mode16`=1), a word takes two halfword data cycles, bits 15:0 first. Halfwords travel on all 16 pins. `ad_oe` is 2'b11 for writes and 2'b00 for reads.
- R4: The first bus cycle of every accepted command is an address-latch cycle. During it `ale` is high, `ad_out` carries the full 16-bit unit address and `ad_oe` is 2'b11.
- R5: In narrow mode with a non-zero stride, a latch cycle is inserted before a byte only when its address bits 15:8 differ from those last latched.
- R6: In wide mode with a non-zero stride, every halfword data cycle is preceded by a latch cycle.
- R7: With a zero stride, a command issues exactly one latch cycle in total.
- R8: Each latch cycle and each data cycle lasts `dur` core clocks. A `dur` of 0 counts as 1.
- R9: For a read, `rd_valid` pulses for one clock in the cycle after the last data clock of each word, with the assembled word on `rd_data`. There is one pulse per word.
- R10: For a write, one word is taken per `wd_valid`/`wd_ready` handshake before that word's bus cycles begin. `wd_ready` is high only while the sequencer waits for that word.
- R11: `busy` rises in the cycle after a command is accepted and falls after the final data clock of the last word. `cmd_ready` is high only when idle. A command with count 0 is accepted and produces no bus cycle.
- R12: `ale`, `rd_stb` and `wr_stb` are mutually exclusive.
- R13: The unit address advances by the stride after every data cycle, modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| mode16 | input | 1 | 0 selects byte-wide data cycles, 1 selects halfword data cycles; sampled at command acceptance |
| dur | input | 4 | Core clocks per latch or data cycle (0 acts as 1) |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Command accepted when high together with `cmd_valid` |
| cmd_write | input | 1 | 1 for write, 0 for read |
| cmd_addr | input | 16 | Start unit address (byte or halfword) |
| cmd_stride | input | 8 | Unsigned address increment per data cycle |
| cmd_count | input | 8 | Number of 32-bit words |
| wd_valid | input | 1 | Write word available |
| wd_ready | output | 1 | Sequencer takes the write word |
| wd_data | input | 32 | Write word |
| rd_valid | output | 1 | One-clock pulse: read word complete |
| rd_data | output | 32 | Assembled read word |
| busy | output | 1 | Command in progress |
| ale | output | 1 | Address-latch strobe |
| rd_stb | output | 1 | Read data strobe |
| wr_stb | output | 1 | Write data strobe |
| ad_out | output | 16 | Multiplexed address/data pins, driven value |
| ad_oe | output | 2 | Output enable per pin byte (bit 1 = pins 15:8) |
| ad_in | input | 16 | Multiplexed pins, sampled value |

## Verification
The checker takes `dur` to be constant while `busy` is high. Its latch-length property compares each `ale` pulse against the current setting, so a mid-command change of `dur` would break that property. The stimulus changes `dur` only between commands, while the block is idle. The checker also takes `cmd_valid` to be raised only with a fully formed command. The bench holds every command field steady for the single clock in which it asserts `cmd_valid`, and keeps `wd_valid` high so that every write wait lasts exactly one clock.

// File: rtl/mpp_pkg.sv
package mpp_pkg;

    localparam int ADDR_W     = 16;
    localparam int PIN_W      = 16;
    localparam int WORD_W     = 32;
    localparam int STRIDE_W   = 8;
    localparam int COUNT_W    = 8;
    localparam int DUR_W      = 4;
    localparam int PAGE_BITS  = 8;
    localparam int HI_W       = ADDR_W - PAGE_BITS;
    localparam int BYTE_LANES = WORD_W / 8;
    localparam int HALF_LANES = WORD_W / 16;
    localparam int LANE_W     = $clog2(BYTE_LANES);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAITW,
        ST_ALE,
        ST_DATA
    } seq_state_e;

    // Per-command settings captured at acceptance
    typedef struct packed {
        logic                write;
        logic                wide;
        logic [ADDR_W-1:0]   addr;
        logic [STRIDE_W-1:0] stride;
    } run_cfg_t;

    // Everything that leaves the block on the bus side
    typedef struct packed {
        logic             ale;
        logic             rd;
        logic             wr;
        logic [1:0]       oe;
        logic [PIN_W-1:0] ad;
    } pin_drive_t;

    function automatic logic [DUR_W-1:0] eff_dur(input logic [DUR_W-1:0] d);
        return (d == '0) ? DUR_W'(1) : d;
    endfunction

    function automatic logic [LANE_W-1:0] last_lane(input logic wide);
        return wide ? LANE_W'(HALF_LANES - 1) : LANE_W'(BYTE_LANES - 1);
    endfunction

    // Decide whether an address phase must precede the data cycle at addr
    function automatic logic ale_needed(
        input logic              wide,
        input logic              stride_zero,
        input logic              pending,
        input logic [ADDR_W-1:0] addr,
        input logic [HI_W-1:0]   held_hi
    );
        if (pending)     return 1'b1;
        if (stride_zero) return 1'b0;
        if (wide)        return 1'b1;
        return addr[ADDR_W-1:PAGE_BITS] != held_hi;
    endfunction

endpackage

// File: rtl/mpp_cycle_timer.sv
module mpp_cycle_timer
    import mpp_pkg::*;
#(
    parameter int CNT_W = DUR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] dur,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] span;

    assign span = (dur == '0) ? CNT_W'(1) : dur;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= span - CNT_W'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign last = (cnt_q == '0);

endmodule

// File: rtl/mpp_ale_tracker.sv
module mpp_ale_tracker
    import mpp_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            mode16,
    input  logic            force_ale,
    input  logic            ale_done,
    input  logic [HI_W-1:0] ale_hi,
    output logic            pending,
    output logic [HI_W-1:0] held_hi
);
    logic mode_q;
    logic pend_q;
    logic [HI_W-1:0] hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= 1'b0;
            pend_q <= 1'b1;
            hi_q   <= '0;
        end else begin
            mode_q <= mode16;
            if (force_ale || (mode16 != mode_q)) begin
                pend_q <= 1'b1;
            end else if (ale_done) begin
                pend_q <= 1'b0;
            end
            if (ale_done) begin
                hi_q <= ale_hi;
            end
        end
    end

    assign pending = pend_q;
    assign held_hi = hi_q;

endmodule

// File: rtl/mpp_lane_unit.sv
module mpp_lane_unit
    import mpp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] wdata,
    input  logic              cap,
    input  logic              wide,
    input  logic [LANE_W-1:0] lane,
    input  logic [PIN_W-1:0]  pin_in,
    output logic [PIN_W-1:0]  lane_out,
    output logic [WORD_W-1:0] word
);
    logic [WORD_W-1:0] word_q;
    logic [7:0]        bytes [BYTE_LANES];
    logic [15:0]       halves [HALF_LANES];

    for (genvar g = 0; g < BYTE_LANES; g++) begin : g_byte
        assign bytes[g] = word_q[8*g +: 8];
    end
    for (genvar h = 0; h < HALF_LANES; h++) begin : g_half
        assign halves[h] = word_q[16*h +: 16];
    end

    always_comb begin
        if (wide) begin
            lane_out = halves[lane[0]];
        end else begin
            lane_out = {8'h00, bytes[lane]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else if (load) begin
            word_q <= wdata;
        end else if (cap) begin
            if (wide) begin
                word_q[16*lane[0] +: 16] <= pin_in;
            end else begin
                word_q[8*lane +: 8] <= pin_in[7:0];
            end
        end
    end

    assign word = word_q;

endmodule

// File: rtl/mpp_sequencer.sv
module mpp_sequencer
    import mpp_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                mode16,
    input  logic [DUR_W-1:0]    dur,
    input  logic                cmd_valid,
    output logic                cmd_ready,
    input  logic                cmd_write,
    input  logic [ADDR_W-1:0]   cmd_addr,
    input  logic [STRIDE_W-1:0] cmd_stride,
    input  logic [COUNT_W-1:0]  cmd_count,
    input  logic                wd_valid,
    output logic                wd_ready,
    input  logic [WORD_W-1:0]   wd_data,
    output logic                rd_valid,
    output logic [WORD_W-1:0]   rd_data,
    output logic                busy,
    output logic                ale,
    output logic                rd_stb,
    output logic                wr_stb,
    output logic [PIN_W-1:0]    ad_out,
    output logic [1:0]          ad_oe,
    input  logic [PIN_W-1:0]    ad_in
);
    seq_state_e         st_q, st_n;
    run_cfg_t           cfg_q;
    logic [COUNT_W-1:0] cnt_q;
    logic [LANE_W-1:0]  lane_q;
    logic               rdv_q;

    logic               tmr_load, tmr_last;
    logic               accept, wd_take, ale_done, data_done, cap;
    logic               pending;
    logic [HI_W-1:0]    held_hi;
    logic [ADDR_W-1:0]  nxt_addr;
    logic               stride_zero, lane_end, need_here, need_next;
    logic [PIN_W-1:0]   lane_out;
    pin_drive_t         drv;

    // ------------------------------------------------------------------
    // Sub-blocks
    // ------------------------------------------------------------------
    mpp_cycle_timer #(.CNT_W(DUR_W)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (tmr_load),
        .dur  (dur),
        .last (tmr_last)
    );

    mpp_ale_tracker u_track (
        .clk       (clk),
        .rst       (rst),
        .mode16    (mode16),
        .force_ale (accept),
        .ale_done  (ale_done),
        .ale_hi    (cfg_q.addr[ADDR_W-1:PAGE_BITS]),
        .pending   (pending),
        .held_hi   (held_hi)
    );

    mpp_lane_unit u_lanes (
        .clk      (clk),
        .rst      (rst),
        .load     (wd_take),
        .wdata    (wd_data),
        .cap      (cap),
        .wide     (cfg_q.wide),
        .lane     (lane_q),
        .pin_in   (ad_in),
        .lane_out (lane_out),
        .word     (rd_data)
    );

    // ------------------------------------------------------------------
    // Address-phase decisions
    // ------------------------------------------------------------------
    assign nxt_addr    = cfg_q.addr + ADDR_W'(cfg_q.stride);
    assign stride_zero = (cfg_q.stride == '0);
    assign lane_end    = (lane_q == last_lane(cfg_q.wide));
    assign need_here   = ale_needed(cfg_q.wide, stride_zero, pending,
                                    cfg_q.addr, held_hi);
    assign need_next   = ale_needed(cfg_q.wide, stride_zero, pending,
                                    nxt_addr, held_hi);

    assign accept    = (st_q == ST_IDLE) && cmd_valid;
    assign wd_take   = (st_q == ST_WAITW) && wd_valid;
    assign ale_done  = (st_q == ST_ALE) && tmr_last;
    assign data_done = (st_q == ST_DATA) && tmr_last;
    assign cap       = data_done && !cfg_q.write;

    // ------------------------------------------------------------------
    // Sequencing
    // ------------------------------------------------------------------
    always_comb begin
        st_n     = st_q;
        tmr_load = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (cmd_valid && (cmd_count != '0)) begin
                    if (cmd_write) begin
                        st_n = ST_WAITW;
                    end else begin
                        st_n     = ST_ALE;
                        tmr_load = 1'b1;
                    end
                end
            end
            ST_WAITW: begin
                if (wd_valid) begin
                    st_n     = need_here ? ST_ALE : ST_DATA;
                    tmr_load = 1'b1;
                end
            end
            ST_ALE: begin
                if (tmr_last) begin
                    st_n     = ST_DATA;
                    tmr_load = 1'b1;
                end
            end
            ST_DATA: begin
                if (tmr_last) begin
                    if (lane_end && (cnt_q == COUNT_W'(1))) begin
                        st_n = ST_IDLE;
                    end else if (lane_end && cfg_q.write) begin
                        st_n = ST_WAITW;
                    end else begin
                        st_n     = need_next ? ST_ALE : ST_DATA;
                        tmr_load = 1'b1;
                    end
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            cfg_q  <= '0;
            cnt_q  <= '0;
            lane_q <= '0;
            rdv_q  <= 1'b0;
        end else begin
            st_q  <= st_n;
            rdv_q <= 1'b0;
            if (accept) begin
                cfg_q.write  <= cmd_write;
                cfg_q.wide   <= mode16;
                cfg_q.addr   <= cmd_addr;
                cfg_q.stride <= cmd_stride;
                cnt_q        <= cmd_count;
                lane_q       <= '0;
            end
            if (data_done) begin
                cfg_q.addr <= nxt_addr;
                if (lane_end) begin
                    lane_q <= '0;
                    cnt_q  <= cnt_q - COUNT_W'(1);
                    rdv_q  <= !cfg_q.write;
                end else begin
                    lane_q <= lane_q + LANE_W'(1);
                end
            end
        end
    end

    // ------------------------------------------------------------------
    // Pin drive
    // ------------------------------------------------------------------
    always_comb begin
        drv = '0;
        unique case (st_q)
            ST_ALE: begin
                drv.ale = 1'b1;
                drv.oe  = 2'b11;
                drv.ad  = cfg_q.addr;
            end
            ST_DATA: begin
                drv.rd = !cfg_q.write;
                drv.wr = cfg_q.write;
                if (cfg_q.wide) begin
                    drv.oe = cfg_q.write ? 2'b11 : 2'b00;
                    drv.ad = cfg_q.write ? lane_out : '0;
                end else begin
                    drv.oe = cfg_q.write ? 2'b11 : 2'b10;
                    drv.ad = {cfg_q.addr[7:0],
                              cfg_q.write ? lane_out[7:0] : 8'h00};
                end
            end
            default: drv = '0;
        endcase
    end

    assign ale       = drv.ale;
    assign rd_stb    = drv.rd;
    assign wr_stb    = drv.wr;
    assign ad_oe     = drv.oe;
    assign ad_out    = drv.ad;
    assign busy      = (st_q != ST_IDLE);
    assign cmd_ready = (st_q == ST_IDLE);
    assign wd_ready  = (st_q == ST_WAITW);
    assign rd_valid  = rdv_q;

endmodule

// File: rtl/mpp_sequencer_chk.sv
module mpp_sequencer_chk
    import mpp_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [DUR_W-1:0] dur,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic             busy,
    input logic             ale,
    input logic             rd_stb,
    input logic             wr_stb,
    input logic [1:0]       ad_oe,
    input logic             rd_valid,
    input logic             wd_ready
);
    logic             seen_ale_q;
    logic [DUR_W:0]   ale_run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_ale_q <= 1'b0;
            ale_run_q  <= '0;
        end else begin
            if (cmd_valid && cmd_ready) begin
                seen_ale_q <= 1'b0;
            end else if (ale) begin
                seen_ale_q <= 1'b1;
            end
            ale_run_q <= ale ? ale_run_q + 1'b1 : '0;
        end
    end

    // R12
    a_r12_strobe_excl: assert property (@(posedge clk) disable iff (rst)
        !(ale && (rd_stb || wr_stb)) && !(rd_stb && wr_stb));

    // R4
    a_r4_ale_before_data: assert property (@(posedge clk) disable iff (rst)
        (rd_stb || wr_stb) |-> seen_ale_q);

    // R4
    a_r4_ale_drives_pins: assert property (@(posedge clk) disable iff (rst)
        ale |-> (ad_oe == 2'b11));

    // R11
    a_r11_ready_when_idle: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> !busy);

    // R9
    a_r9_rdv_follows_read: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(rd_stb));

    // R9
    a_r9_rdv_single: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    // R10
    a_r10_wait_quiet: assert property (@(posedge clk) disable iff (rst)
        wd_ready |-> (busy && !ale && !rd_stb && !wr_stb));

    // R8 (dur held constant while busy)
    a_r8_ale_length: assert property (@(posedge clk) disable iff (rst)
        $fell(ale) |-> (ale_run_q == {1'b0, eff_dur(dur)}));

endmodule

bind mpp_sequencer mpp_sequencer_chk u_chk (.*);

// File: tb/tb_mpp_sequencer.sv
`timescale 1ns/1ps
module tb_mpp_sequencer;
    import mpp_pkg::*;

    // {wide, write, addr, stride, count, dur, expected latch cycles}
    typedef struct packed {
        logic        wide;
        logic        write;
        logic [15:0] addr;
        logic [7:0]  stride;
        logic [7:0]  count;
        logic [3:0]  dur;
        logic [7:0]  ales;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        {1'b0, 1'b0, 16'h12FE, 8'h01, 8'd2, 4'd3,  8'd2},  // narrow read across page
        {1'b0, 1'b1, 16'h12FE, 8'h01, 8'd2, 4'd3,  8'd2},  // narrow write across page
        {1'b0, 1'b0, 16'h0400, 8'h00, 8'd3, 4'd2,  8'd1},  // zero stride
        {1'b1, 1'b0, 16'h0100, 8'h01, 8'd2, 4'd1,  8'd4},  // wide read
        {1'b1, 1'b1, 16'h0200, 8'h00, 8'd2, 4'd0,  8'd1},  // wide write zero stride, dur 0
        {1'b0, 1'b0, 16'h0080, 8'h40, 8'd1, 4'd1,  8'd2},  // large stride
        {1'b1, 1'b1, 16'h8000, 8'h02, 8'd1, 4'd5,  8'd2},  // wide write stride 2
        {1'b0, 1'b1, 16'h00FF, 8'h01, 8'd1, 4'd1,  8'd2},  // page edge on first byte
        {1'b0, 1'b0, 16'h3300, 8'h01, 8'd3, 4'd15, 8'd1},  // long duration
        {1'b0, 1'b0, 16'hFF80, 8'h80, 8'd1, 4'd1,  8'd3}   // address wrap
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        mode16;
    logic [3:0]  dur;
    logic        cmd_valid, cmd_ready, cmd_write;
    logic [15:0] cmd_addr;
    logic [7:0]  cmd_stride, cmd_count;
    logic        wd_valid, wd_ready;
    logic [31:0] wd_data;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        busy, ale, rd_stb, wr_stb;
    logic [15:0] ad_out, ad_in;
    logic [1:0]  ad_oe;

    always #10 clk = ~clk;

    mpp_sequencer dut (
        .clk(clk), .rst(rst), .mode16(mode16), .dur(dur),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_stride(cmd_stride), .cmd_count(cmd_count),
        .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data),
        .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy), .ale(ale),
        .rd_stb(rd_stb), .wr_stb(wr_stb), .ad_out(ad_out), .ad_oe(ad_oe),
        .ad_in(ad_in)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] mem8(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
    endfunction
    function automatic logic [15:0] mem16(input logic [15:0] a);
        return {a[7:0], a[15:8]} ^ 16'h9E37;
    endfunction
    function automatic logic [31:0] wword(input int v, input int w);
        return 32'h8C4E2A17 ^ {v[7:0], w[7:0], v[7:0], w[7:0]} ^ (w * 32'h01030507);
    endfunction

    // Bus-side memory model: address comes from latch cycles and pins
    logic [15:0] lat = '0;
    always @(negedge clk) if (ale) lat = ad_out;
    assign ad_in = mode16 ? mem16(lat) : {8'h00, mem8({lat[15:8], ad_out[15:8]})};

    // Current command as seen by the monitor
    vec_t cur;
    int   cur_vi = 0;
    int   ale_clk, dat_clk, busy_clk, units, rdv_cnt, widx, phase;
    bit   prev_ready;
    logic [15:0] first_ale;
    bit   got_ale;

    function automatic int lanes(input logic wide);
        return wide ? 2 : 4;
    endfunction
    function automatic logic [15:0] unit_addr(input int u);
        return cur.addr + 16'(u * int'(cur.stride));
    endfunction
    function automatic logic [31:0] exp_read(input int w);
        logic [31:0] r = '0;
        for (int l = 0; l < lanes(cur.wide); l++) begin
            if (cur.wide) r[16*l +: 16] = mem16(unit_addr(w*2 + l));
            else          r[8*l +: 8]   = mem8(unit_addr(w*4 + l));
        end
        return r;
    endfunction

    always @(negedge clk) begin
        if (!rst) begin
            // write-word feeder
            if (prev_ready) begin
                widx++;
                wd_data = wword(cur_vi, widx);
            end
            prev_ready = wd_ready;
            if (ale) begin
                ale_clk++;
                if (!got_ale) begin
                    got_ale   = 1;
                    first_ale = ad_out;
                end
            end
            if (busy) busy_clk++;
            if (rd_stb || wr_stb) begin
                dat_clk++;
                if (phase == 0) begin
                    int l, w;
                    logic [15:0] a;
                    l = units % lanes(cur.wide);
                    w = units / lanes(cur.wide);
                    a = unit_addr(units);
                    if (wr_stb) begin
                        logic [31:0] ww;
                        ww = wword(cur_vi, w);
                        if (cur.wide)
                            chk(ad_out == ww[16*l +: 16], "R3", "write halfword",
                                ad_out, ww[16*l +: 16]);
                        else begin
                            chk(ad_out[7:0] == ww[8*l +: 8], "R2", "write byte",
                                ad_out[7:0], ww[8*l +: 8]);
                            chk(ad_out[15:8] == a[7:0], "R13", "low address on pins",
                                ad_out[15:8], a[7:0]);
                        end
                    end else begin
                        chk(ad_oe == (cur.wide ? 2'b00 : 2'b10),
                            cur.wide ? "R3" : "R2", "read pin enable", ad_oe,
                            cur.wide ? 2'b00 : 2'b10);
                    end
                    units++;
                end
                phase = (phase + 1 >= int'(eff_dur(cur.dur))) ? 0 : phase + 1;
            end else begin
                phase = 0;
            end
            if (rd_valid) begin
                logic [31:0] e;
                e = exp_read(rdv_cnt);
                chk(rd_data == e, cur.wide ? "R3" : "R2", "read word", rd_data, e);
                rdv_cnt++;
            end
        end
    end

    task automatic run_cmd(input vec_t v, input int vi);
        int guard;
        int d, nunits, exp_busy;
        @(negedge clk);
        cur = v; cur_vi = vi;
        ale_clk = 0; dat_clk = 0; busy_clk = 0; units = 0; rdv_cnt = 0;
        widx = 0; phase = 0; prev_ready = 0; got_ale = 0; first_ale = '0;
        wd_data    = wword(vi, 0);
        mode16     = v.wide;
        dur        = v.dur;
        cmd_write  = v.write;
        cmd_addr   = v.addr;
        cmd_stride = v.stride;
        cmd_count  = v.count;
        cmd_valid  = 1'b1;
        chk(cmd_ready == 1'b1, "R11", "ready before command", cmd_ready, 1);
        @(negedge clk);
        cmd_valid = 1'b0;
        if (v.count != 0)
            chk(busy && !cmd_ready, "R11", "busy after accept", {busy, cmd_ready}, 2'b10);
        guard = 0;
        while (busy && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
        d        = int'(eff_dur(v.dur));
        nunits   = int'(v.count) * lanes(v.wide);
        exp_busy = (int'(v.ales) + nunits) * d + (v.write ? int'(v.count) : 0);
        chk(ale_clk == int'(v.ales) * d,
            (v.stride == 0) ? "R7" : (v.wide ? "R6" : "R5"),
            "latch clocks", ale_clk, int'(v.ales) * d);
        chk(dat_clk == nunits * d, "R8", "data clocks", dat_clk, nunits * d);
        chk(units == nunits, "R13", "data cycles", units, nunits);
        chk(busy_clk == exp_busy, "R11", "busy clocks", busy_clk, exp_busy);
        if (v.count != 0)
            chk(got_ale && first_ale == v.addr, "R4", "first latch address",
                first_ale, v.addr);
        if (v.write)
            chk(widx == int'(v.count), "R10", "words taken", widx, v.count);
        else
            chk(rdv_cnt == int'(v.count), "R9", "read pulses", rdv_cnt, v.count);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; mode16 = 0; dur = 4'd1; cmd_valid = 0; cmd_write = 0;
        cmd_addr = '0; cmd_stride = '0; cmd_count = '0; wd_valid = 1'b1;
        wd_data = '0; cur = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!ale && !rd_stb && !wr_stb && !busy && !rd_valid && !wd_ready,
            "R1", "strobes after reset",
            {ale, rd_stb, wr_stb, busy, rd_valid, wd_ready}, 0);
        chk(ad_oe == 2'b00 && cmd_ready, "R1", "pins and ready after reset",
            {ad_oe, cmd_ready}, 3'b001);

        for (int i = 0; i < NVEC; i++) run_cmd(VECS[i], i);

        // R11 zero-count command: no bus activity
        run_cmd({1'b0, 1'b0, 16'h5555, 8'h01, 8'd0, 4'd2, 8'd0}, 20);
        repeat (4) @(negedge clk);
        chk(ale_clk == 0 && dat_clk == 0 && !busy, "R11", "zero count idle",
            ale_clk + dat_clk, 0);

        // R10 no write-data request while idle
        chk(!wd_ready, "R10", "wd_ready idle", wd_ready, 0);

        // R12 strobes are exclusive over a mixed run
        run_cmd({1'b1, 1'b0, 16'h0700, 8'h03, 8'd1, 4'd2, 8'd2}, 21);
        chk(!(ale || rd_stb || wr_stb), "R12", "quiet after run",
            {ale, rd_stb, wr_stb}, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule